// File: doc/BRIEF.md
# Boundary Scan Cell Register

This block is a parameterised chain of generic boundary-scan cells, one cell per device pin. Each cell sits in a pin's functional path. It can either pass the live value straight through or drive a value that was loaded over the serial test path. Under control of the test-port state machine, each cell can take a snapshot of its parallel input, move that snapshot one place along the serial chain, and copy the chain contents into a separate holding stage that drives the pin when test mode is selected.

All storage runs on the dedicated test clock, `tck`, which is kept separate from any system clock. The capture-clock and update-clock strobes from the state machine act as synchronous enables on that clock. The serial path runs from `tdi` into cell 0, then through cell 1 and onward to cell CELLS-1, whose capture stage drives `tdo`. Capture and shift touch only the first stage of each cell. In pass-through mode the functional path therefore carries live data undisturbed while values are sampled and scanned out.

Top module: `bsr_chain`

## Requirements
- R1: While `rst_n` is low, the capture stage and the update stage of every cell are 0. Just after reset, `tdo` is 0, and `pin_out` is all zeros when `mode` is 1.
- R2: When `mode` is 0, `pin_out[i]` equals `pin_in[i]` combinationally for every cell, whatever `capture_en`, `shift_en` and `update_en` are doing.
- R3: When `mode` is 1, `pin_out[i]` equals the update stage of cell i.
- R4: On a rising `tck` edge with `capture_en`=1 and `shift_en`=0, the capture stage of every cell i loads `pin_in[i]`.
- R5: On a rising `tck` edge with `capture_en`=1 and `shift_en`=1, cell 0's capture stage loads `tdi` and cell i loads cell i-1's old capture value. `tdo` always shows cell CELLS-1's capture stage, so a bit on `tdi` reaches `tdo` after CELLS shift edges.
- R6: On a rising `tck` edge with `update_en`=1, each update stage loads its cell's capture value. With `update_en`=0 the update stage holds, even while shifting.
- R7: With `capture_en`=0 the capture stages hold their values, even when `shift_en` is 1.
- R8: When `capture_en` and `update_en` are both 1 on the same edge, the update stage takes the capture value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Dedicated test clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset of all cell stages |
| capture_en | input | 1 | Capture-clock strobe: first stage loads on this edge |
| shift_en | input | 1 | Selects the serial input (1) or the parallel input (0) for the first stage |
| update_en | input | 1 | Update-clock strobe: second stage loads on this edge |
| mode | input | 1 | Output select: 0 passes `pin_in`, 1 drives the update stage |
| tdi | input | 1 | Serial test data into cell 0 |
| pin_in | input | CELLS | Parallel inputs, one per cell |
| pin_out | output | CELLS | Parallel outputs, one per cell |
| tdo | output | 1 | Serial test data from the capture stage of cell CELLS-1 |

## Verification
Parallel capture is tried with patterns such as 0xA5, 0x3C and walking single bits. Each is read back serially at `tdo`, which tells a correct cell-to-bit order from a reversed or off-by-one chain. Serially loaded words that differ from what is captured, followed by update and `mode`=1, tell apart the update stage, the capture stage and the live input. A shift without an update strobe confirms that the driven pins hold. A combined capture-and-update edge tells whether the update stage takes the old or the new capture value. Pass-through is checked with several `pin_in` values while shifting is in progress.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic {
    OUT_LIVE  = 1'b0,
    OUT_HELD  = 1'b1
  } out_sel_e;

  // Front-end choice of the first stage: serial neighbour or parallel pin.
  function automatic logic pick_capture(input logic shifting,
                                        input logic serial_bit,
                                        input logic parallel_bit);
    return shifting ? serial_bit : parallel_bit;
  endfunction

  // Back-end choice of the parallel output.
  function automatic logic pick_output(input out_sel_e sel,
                                       input logic live_bit,
                                       input logic held_bit);
    return (sel == OUT_HELD) ? held_bit : live_bit;
  endfunction

endpackage

// File: rtl/bsr_capture_stage.sv
module bsr_capture_stage
  import bsr_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic capture_en,
  input  logic shift_en,
  input  logic ser_in,
  input  logic par_in,
  output logic cap_q
);

  logic cap_d;
  logic cap_load;

  assign cap_d    = pick_capture(shift_en, ser_in, par_in);
  assign cap_load = capture_en;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        cap_q <= 1'b0;
    else if (cap_load) cap_q <= cap_d;
  end

  // R5
  shift_move_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_en && shift_en) |=> (cap_q == $past(ser_in)));

  // R4
  parallel_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_en && !shift_en) |=> (cap_q == $past(par_in)));

  // R7
  capture_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !capture_en |=> $stable(cap_q));

endmodule

// File: rtl/bsr_update_stage.sv
module bsr_update_stage (
  input  logic tck,
  input  logic rst_n,
  input  logic update_en,
  input  logic cap_q,
  output logic upd_q
);

  logic upd_load;
  assign upd_load = update_en;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        upd_q <= 1'b0;
    else if (upd_load) upd_q <= cap_q;
  end

  // R6 R8
  update_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
    update_en |=> (upd_q == $past(cap_q)));

  // R6
  update_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !update_en |=> $stable(upd_q));

endmodule

// File: rtl/bsr_out_mux.sv
module bsr_out_mux
  import bsr_pkg::*;
(
  input  out_sel_e sel,
  input  logic     live_bit,
  input  logic     held_bit,
  output logic     out_bit
);

  assign out_bit = pick_output(sel, live_bit, held_bit);

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
(
  input  logic     tck,
  input  logic     rst_n,
  input  logic     capture_en,
  input  logic     shift_en,
  input  logic     update_en,
  input  out_sel_e sel,
  input  logic     ser_in,
  input  logic     par_in,
  output logic     par_out,
  output logic     ser_out
);

  logic cap_q;
  logic upd_q;

  bsr_capture_stage u_cap (
    .tck        (tck),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .shift_en   (shift_en),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .cap_q      (cap_q)
  );

  bsr_update_stage u_upd (
    .tck       (tck),
    .rst_n     (rst_n),
    .update_en (update_en),
    .cap_q     (cap_q),
    .upd_q     (upd_q)
  );

  bsr_out_mux u_mux (
    .sel      (sel),
    .live_bit (par_in),
    .held_bit (upd_q),
    .out_bit  (par_out)
  );

  assign ser_out = cap_q;

  // R3
  held_drive_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (sel == OUT_HELD) |-> (par_out == upd_q));

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             capture_en,
  input  logic             shift_en,
  input  logic             update_en,
  input  logic             mode,
  input  logic             tdi,
  input  logic [CELLS-1:0] pin_in,
  output logic [CELLS-1:0] pin_out,
  output logic             tdo
);

  localparam int LINKS = CELLS + 1;

  logic [LINKS-1:0] scan_link;
  out_sel_e         sel;

  assign sel          = out_sel_e'(mode);
  assign scan_link[0] = tdi;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    bsr_cell u_cell (
      .tck        (tck),
      .rst_n      (rst_n),
      .capture_en (capture_en),
      .shift_en   (shift_en),
      .update_en  (update_en),
      .sel        (sel),
      .ser_in     (scan_link[i]),
      .par_in     (pin_in[i]),
      .par_out    (pin_out[i]),
      .ser_out    (scan_link[i+1])
    );
  end

  assign tdo = scan_link[LINKS-1];

  // R5
  tdo_follow_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (capture_en && shift_en) |=> (tdo == $past(scan_link[LINKS-2])));

endmodule

// File: tb/tb_bsr_chain.sv
module tb_bsr_chain;
  localparam int N = 8;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, mode = 1'b0, tdi = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out;
  logic tdo;

  int total = 0;
  int bad = 0;

  always #2.5 tck = ~tck;

  bsr_chain #(.CELLS(N)) dut (
    .tck(tck), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
    .update_en(update_en), .mode(mode), .tdi(tdi), .pin_in(pin_in),
    .pin_out(pin_out), .tdo(tdo)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One rising edge with the given strobes; returns at the following falling edge.
  task automatic step(input logic c, input logic s, input logic u, input logic d);
    @(negedge tck);
    capture_en = c; shift_en = s; update_en = u; tdi = d;
    @(negedge tck);
    capture_en = 0; shift_en = 0; update_en = 0;
  endtask

  // Serially load word w so that cell i ends holding w[i].
  task automatic load_word(input logic [N-1:0] w);
    for (int k = N-1; k >= 0; k--) step(1, 1, 0, w[k]);
  endtask

  // Shift the chain out, returning bits so that result[i] is cell i's value.
  task automatic read_word(output logic [N-1:0] w);
    for (int k = N-1; k >= 0; k--) begin
      w[k] = tdo;
      step(1, 1, 0, 1'b0);
    end
  endtask

  task automatic do_reset();
    @(negedge tck);
    rst_n = 0;
    #7;
    @(negedge tck);
    rst_n = 1;
  endtask

  task automatic t_reset();
    logic [N-1:0] w;
    do_reset();
    mode = 1;
    #1;
    check("R1 tdo after reset", tdo, 0);
    check("R1 held outputs after reset", pin_out, 0);
    load_word(8'hFF);
    step(0, 0, 1, 0);
    check("R1 pre-reset load visible", pin_out, 8'hFF);
    do_reset();
    #1;
    check("R1 held outputs cleared", pin_out, 0);
    check("R1 tdo cleared", tdo, 0);
    read_word(w);
    check("R1 capture stages cleared", w, 0);
    mode = 0;
  endtask

  task automatic t_passthrough();
    mode = 0;
    pin_in = 8'h5A; #1;
    check("R2 pass 5A", pin_out, 8'h5A);
    pin_in = 8'hC3; #1;
    check("R2 pass C3", pin_out, 8'hC3);
    @(negedge tck);
    capture_en = 1; shift_en = 1; update_en = 1; tdi = 1;
    pin_in = 8'h0F; #1;
    check("R2 pass during shift and update", pin_out, 8'h0F);
    @(negedge tck);
    capture_en = 0; shift_en = 0; update_en = 0;
    pin_in = 8'hF0; #1;
    check("R2 pass after activity", pin_out, 8'hF0);
  endtask

  task automatic t_capture();
    logic [N-1:0] pats [4] = '{8'hA5, 8'h3C, 8'h01, 8'h80};
    logic [N-1:0] w;
    foreach (pats[p]) begin
      pin_in = pats[p];
      step(1, 0, 0, 0);
      read_word(w);
      check("R4 R5 capture then scan out", w, pats[p]);
    end
  endtask

  task automatic t_latency();
    do_reset();
    step(1, 1, 0, 1);
    for (int k = 1; k < N; k++) begin
      check("R5 bit not yet at tdo", tdo, 0);
      step(1, 1, 0, 0);
    end
    check("R5 bit reaches tdo after CELLS shifts", tdo, 1);
  endtask

  task automatic t_update();
    logic [N-1:0] w;
    mode = 1;
    pin_in = 8'hFF;
    load_word(8'h96);
    step(0, 0, 1, 0);
    check("R3 R6 driven word", pin_out, 8'h96);
    load_word(8'h21);
    check("R6 held during shift", pin_out, 8'h96);
    // shift_en alone with no capture strobe
    step(0, 1, 0, 1);
    step(0, 1, 0, 1);
    read_word(w);
    check("R7 no move without capture strobe", w, 8'h21);
    check("R6 still held", pin_out, 8'h96);
    mode = 0;
  endtask

  task automatic t_same_edge();
    mode = 1;
    load_word(8'h4B);
    pin_in = 8'hE2;
    step(1, 0, 1, 0);
    check("R8 update took old capture value", pin_out, 8'h4B);
    step(0, 0, 1, 0);
    check("R8 next update takes captured pins", pin_out, 8'hE2);
    mode = 0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_passthrough();
    t_capture();
    t_latency();
    t_update();
    t_same_edge();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule